// File: doc/BRIEF.md
# GPIO Interrupt Source Router

This block routes general-purpose input lines onto eight parent interrupt lines. Each parent channel has its own source index, which picks one GPIO line. It also has a trigger mode, level or edge, and a polarity, high/rising or low/falling. Every GPIO input first passes through a two-flop synchronizer. A level channel then follows its chosen line. An edge channel keeps a sticky pending flag, and software clears that flag by writing a one to it.

Software reaches the block through a 32-bit word-addressed register port with a write strobe and a combinational read path. A channel watches one edge direction only. To catch both edges of one line, software routes the line to two channels of opposite polarity. Any index outside the implemented input range leaves the channel quiet. The block also holds a filter-select word for software. It is stored and read back and has no other effect.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, irq_out is 0, word 0 reads 0, words 1 and 2 read 0xFFFFFFFF (every source index 255), word 3 reads 0 and word 4 reads 0.
- R2: Word 1 holds the 8-bit source indices of channels 0..3 and word 2 holds those of channels 4..7. In each word, channel 4k+j sits in bits 8j+7..8j, so the lowest channel is in the lowest byte. Channel c routes GPIO line gpio_in[index].
- R3: A source index of 133 or above (133..255) leaves that channel's irq_out bit at 0 in every mode, whatever the GPIO inputs are.
- R4: In word 0, bit c (c = 0..7) selects edge mode for channel c, and bit 16+c selects low/falling polarity for channel c. Bits 8..15 and 24..31 read as 0.
- R5: In level mode, irq_out[c] equals the selected line, inverted when the polarity bit is set. It responds two clock edges after the GPIO input changes.
- R6: In edge mode, a rising edge sets the channel's pending flag, or a falling edge does when the polarity bit is set. The flag stays set and drives irq_out[c]. Word 4 bits 7..0 read the pending flags.
- R7: Writing word 4 clears each pending flag whose data bit is 1. Flags whose data bit is 0 are left as they are.
- R8: A write that changes a channel's source index, edge bit or polarity bit clears that channel's pending flag. The switch itself never creates an edge.
- R9: Word 3 stores all 32 written bits and reads them back unchanged.
- R10: One GPIO line routed to a rising-edge channel and to a falling-edge channel flags the first on a low-to-high change and the second on a high-to-low change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index (byte offset divided by 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| gpio_in | input | 133 | Asynchronous GPIO input lines |
| irq_out | output | 8 | Parent interrupt lines, one per channel |

## Verification
Level routing is tried in two ways. A one-hot GPIO pattern on an identity mapping exposes byte-lane or channel-order swaps. Random source indices with random polarity masks and random GPIO vectors separate index decoding from inversion. Unassigned indices are driven with all-ones and all-zeros inputs in both polarities, which shows that out-of-range indices stay quiet rather than wrapping. Edge channels get a random sequence of line toggles against a bench model of sticky flags. Directed sequences then isolate selective clearing, configuration switches that would fake an edge, and both-edge detection through paired channels.

// File: rtl/gir_pkg.sv
package gir_pkg;
    localparam int unsigned NCH   = 8;
    localparam int unsigned SEL_W = 8;
    localparam int unsigned DW    = 32;

    typedef logic [SEL_W-1:0] sel_t;
    localparam sel_t SEL_NONE = '1;

    typedef enum logic [2:0] {
        W_TRIG   = 3'd0,
        W_SEL_LO = 3'd1,
        W_SEL_HI = 3'd2,
        W_FILT   = 3'd3,
        W_STAT   = 3'd4
    } word_e;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
    parameter int unsigned W = 133
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1 = async_i;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o = q.s2;
endmodule

// File: rtl/gir_regs.sv
module gir_regs
    import gir_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      reg_word,
    input  logic [DW-1:0]   wdata,
    input  logic [NCH-1:0]  pend_i,
    output logic [DW-1:0]   rdata,
    output sel_t            sel_o [NCH],
    output logic [NCH-1:0]  edge_o,
    output logic [NCH-1:0]  low_o,
    output logic [NCH-1:0]  clr_o,
    output logic [NCH-1:0]  chg_o
);
    localparam int unsigned SELS = NCH * SEL_W;

    typedef struct packed {
        logic [NCH-1:0]  edge_m;
        logic [NCH-1:0]  low_m;
        logic [SELS-1:0] sel;
        logic [DW-1:0]   filt;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d     = q;
        clr_o = '0;
        if (wr_en) begin
            unique case (reg_word)
                W_TRIG: begin
                    d.edge_m = wdata[NCH-1:0];
                    d.low_m  = wdata[16 +: NCH];
                end
                W_SEL_LO: d.sel[DW-1:0]  = wdata;
                W_SEL_HI: d.sel[SELS-1:DW] = wdata;
                W_FILT:   d.filt = wdata;
                W_STAT:   clr_o  = wdata[NCH-1:0];
                default:  ;
            endcase
        end
        for (int c = 0; c < NCH; c++) begin
            chg_o[c] = (d.edge_m[c] != q.edge_m[c]) ||
                       (d.low_m[c]  != q.low_m[c])  ||
                       (d.sel[c*SEL_W +: SEL_W] != q.sel[c*SEL_W +: SEL_W]);
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_word)
            W_TRIG: begin
                rdata[NCH-1:0]  = q.edge_m;
                rdata[16 +: NCH] = q.low_m;
            end
            W_SEL_LO: rdata = q.sel[DW-1:0];
            W_SEL_HI: rdata = q.sel[SELS-1:DW];
            W_FILT:   rdata = q.filt;
            W_STAT:   rdata[NCH-1:0] = pend_i;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.edge_m <= '0;
            q.low_m  <= '0;
            q.sel    <= {NCH{SEL_NONE}};
            q.filt   <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_out
        assign sel_o[c] = q.sel[c*SEL_W +: SEL_W];
    end
    assign edge_o = q.edge_m;
    assign low_o  = q.low_m;

    assert_filt_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_word == W_FILT) |=> (q.filt == $past(wdata)));

    assert_sel_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(q.sel));
endmodule

// File: rtl/gir_channel.sv
module gir_channel
    import gir_pkg::*;
#(
    parameter int unsigned NUM_GPIO = 133
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GPIO-1:0] gpio_s,
    input  sel_t                sel_i,
    input  logic                edge_i,
    input  logic                low_i,
    input  logic                chg_i,
    input  logic                clr_i,
    output logic                irq_o,
    output logic                pend_o
);
    localparam int unsigned PAD = 1 << SEL_W;

    typedef struct packed {
        logic prev;
        logic prev_ok;
        logic pend;
    } ch_t;

    ch_t q, d;
    logic [PAD-1:0] padded;
    logic valid, src, det;

    assign padded = PAD'(gpio_s);

    always_comb begin
        valid = int'(sel_i) < int'(NUM_GPIO);
        src   = valid & padded[sel_i];
        det   = edge_i & valid & q.prev_ok &
                (low_i ? (q.prev & ~src) : (~q.prev & src));
        d.prev = src;
        if (chg_i) begin
            d.pend    = 1'b0;
            d.prev_ok = 1'b0;
        end else begin
            d.pend    = (q.pend & ~clr_i) | det;
            d.prev_ok = valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_o  = valid & (edge_i ? q.pend : (src ^ low_i));
    assign pend_o = q.pend;

    assert_unassigned_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_i) >= int'(NUM_GPIO)) |-> (!irq_o && !q.pend));

    assert_cfg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> !q.pend);

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !det && !chg_i) |=> !q.pend);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && !clr_i && !chg_i) |=> q.pend);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gir_pkg::*;
#(
    parameter int unsigned NUM_GPIO = 133
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          reg_word,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_GPIO-1:0] gpio_in,
    output logic [7:0]          irq_out
);
    logic [NUM_GPIO-1:0] gpio_s;
    sel_t                sel   [NCH];
    logic [NCH-1:0]      edge_m, low_m, clr, chg, pend;

    gir_sync #(.W(NUM_GPIO)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (gpio_in),
        .sync_o  (gpio_s)
    );

    gir_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_word (reg_word),
        .wdata    (wdata),
        .pend_i   (pend),
        .rdata    (rdata),
        .sel_o    (sel),
        .edge_o   (edge_m),
        .low_o    (low_m),
        .clr_o    (clr),
        .chg_o    (chg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gir_channel #(.NUM_GPIO(NUM_GPIO)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .gpio_s (gpio_s),
            .sel_i  (sel[c]),
            .edge_i (edge_m[c]),
            .low_i  (low_m[c]),
            .chg_i  (chg[c]),
            .clr_i  (clr[c]),
            .irq_o  (irq_out[c]),
            .pend_o (pend[c])
        );
    end

    assert_stat_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word == W_STAT) |-> (rdata[7:0] == pend && rdata[31:8] == '0));
endmodule

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/1ps
module gpio_irq_router_bench;
    localparam int NG = 133;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          wr_en = 0;
    logic [2:0]    reg_word = 0;
    logic [31:0]   wdata = 0;
    logic [31:0]   rdata;
    logic [NG-1:0] gpio_in = '0;
    logic [7:0]    irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_sel [8];
    logic [7:0] m_edge, m_low, m_pend;

    always #10 clk = ~clk;

    gpio_irq_router u_gpio_irq_router (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_word(reg_word),
        .wdata(wdata), .rdata(rdata), .gpio_in(gpio_in), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1; reg_word = w; wdata = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [31:0] v);
        @(negedge clk);
        reg_word = w;
        #1 v = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic put_sels();
        wr(3'd1, {m_sel[3], m_sel[2], m_sel[1], m_sel[0]});
        wr(3'd2, {m_sel[7], m_sel[6], m_sel[5], m_sel[4]});
    endtask

    function automatic logic bit_of(input logic [NG-1:0] g, input logic [7:0] s);
        if (int'(s) < NG) return g[s];
        return 1'b0;
    endfunction

    function automatic logic [7:0] level_exp(input logic [NG-1:0] g);
        logic [7:0] r;
        for (int c = 0; c < 8; c++)
            r[c] = (int'(m_sel[c]) < NG) ? (bit_of(g, m_sel[c]) ^ m_low[c]) : 1'b0;
        return r;
    endfunction

    function automatic logic [7:0] edge_hits(input logic [NG-1:0] o, input logic [NG-1:0] n);
        logic [7:0] r;
        for (int c = 0; c < 8; c++) begin
            logic a, b;
            a = bit_of(o, m_sel[c]);
            b = bit_of(n, m_sel[c]);
            r[c] = (int'(m_sel[c]) < NG) && (m_low[c] ? (a && !b) : (!a && b));
        end
        return r;
    endfunction

    function automatic logic [NG-1:0] rand_gpio();
        logic [159:0] w;
        w = {$urandom, $urandom, $urandom, $urandom, $urandom};
        return w[NG-1:0];
    endfunction

    initial begin
        #(20.0 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NG-1:0] g_old, g_new;
        void'($urandom(32'h1234_5678));

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {24'b0, irq_out}, 32'h0);
        rd(3'd0, v); check("R1 trig", v, 32'h0);
        rd(3'd1, v); check("R1 sel lo", v, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R1 sel hi", v, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R1 filt", v, 32'h0);
        rd(3'd4, v); check("R1 stat", v, 32'h0);

        // R9 filter storage
        wr(3'd3, 32'hA5C3_1E7F); rd(3'd3, v); check("R9 filt", v, 32'hA5C3_1E7F);
        wr(3'd3, 32'h5A3C_E180); rd(3'd3, v); check("R9 filt2", v, 32'h5A3C_E180);

        // R4 trigger field layout
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check("R4 trig mask", v, 32'h00FF_00FF);
        wr(3'd0, 32'h0000_0000);

        // R2 select layout and identity routing
        for (int c = 0; c < 8; c++) m_sel[c] = 8'(c);
        m_edge = 0; m_low = 0;
        put_sels();
        rd(3'd1, v); check("R2 sel lo", v, 32'h0302_0100);
        rd(3'd2, v); check("R2 sel hi", v, 32'h0706_0504);
        gpio_in = '0; gpio_in[5] = 1'b1;
        settle(); check("R2 onehot", {24'b0, irq_out}, 32'h20);

        // R5 level timing: changes after second edge
        gpio_in[5] = 1'b0; gpio_in[2] = 1'b1;
        @(negedge clk); check("R5 one edge", {24'b0, irq_out}, 32'h20);
        @(negedge clk); check("R5 two edges", {24'b0, irq_out}, 32'h04);

        // R3 unassigned indices
        m_sel[0] = 8'd133; m_sel[1] = 8'd200; m_sel[2] = 8'd255; m_sel[3] = 8'd132;
        put_sels();
        gpio_in = '1; settle();
        check("R3 high", {24'b0, irq_out}, 32'hF8);
        wr(3'd0, 32'h00FF_0000); m_low = 8'hFF;
        gpio_in = '0; settle();
        check("R3 low", {24'b0, irq_out}, 32'hF8);

        // R5 random level routing
        for (int i = 0; i < 40; i++) begin
            for (int c = 0; c < 8; c++)
                m_sel[c] = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(133, 255))
                                                       : 8'($urandom_range(0, NG - 1));
            m_low = 8'($urandom);
            wr(3'd0, {8'b0, m_low, 16'b0});
            put_sels();
            gpio_in = rand_gpio();
            settle();
            check("R5 level rand", {24'b0, irq_out}, {24'b0, level_exp(gpio_in)});
        end

        // R6 random edge sequences
        for (int c = 0; c < 8; c++) m_sel[c] = 8'($urandom_range(0, 15));
        m_low = 8'($urandom);
        gpio_in = '0; settle();
        wr(3'd0, {8'b0, m_low, 8'b0, 8'hFF});
        put_sels();
        settle();
        wr(3'd4, 32'hFF);
        m_pend = 0;
        g_old = gpio_in;
        for (int i = 0; i < 60; i++) begin
            g_new = g_old;
            g_new[$urandom_range(0, 15)] ^= 1'b1;
            if ($urandom_range(0, 1) == 1) g_new[$urandom_range(0, 15)] ^= 1'b1;
            gpio_in = g_new;
            settle();
            m_pend |= edge_hits(g_old, g_new);
            g_old = g_new;
            check("R6 edge irq", {24'b0, irq_out}, {24'b0, m_pend});
            rd(3'd4, v); check("R6 edge stat", v, {24'b0, m_pend});
            if (i % 15 == 14) begin
                wr(3'd4, 32'hFF); m_pend = 0;
            end
        end

        // R7 write-one-to-clear
        for (int c = 0; c < 8; c++) m_sel[c] = 8'(40 + c);
        wr(3'd0, 32'h0000_00FF); m_low = 0;
        put_sels();
        gpio_in = '0; settle();
        wr(3'd4, 32'hFF);
        gpio_in[47:40] = 8'hFF; settle();
        rd(3'd4, v); check("R7 all set", v, 32'hFF);
        wr(3'd4, 32'h00); rd(3'd4, v); check("R7 zero write", v, 32'hFF);
        wr(3'd4, 32'h24); rd(3'd4, v); check("R7 partial", v, 32'hDB);
        check("R7 irq", {24'b0, irq_out}, 32'hDB);

        // R8 config change: no false edge, pending cleared
        gpio_in[10] = 1'b0; gpio_in[11] = 1'b1;
        m_sel[0] = 8'd10; put_sels(); settle();
        wr(3'd4, 32'hFF);
        m_sel[0] = 8'd11; put_sels(); settle();
        rd(3'd4, v); check("R8 no false edge", v & 32'h1, 32'h0);
        gpio_in[11] = 1'b0; settle(); gpio_in[11] = 1'b1; settle();
        rd(3'd4, v); check("R8 real edge", v & 32'h1, 32'h1);
        wr(3'd0, 32'h0001_00FF); settle();
        rd(3'd4, v); check("R8 trig clears", v & 32'h1, 32'h0);

        // R10 both edges through two channels
        m_sel[0] = 8'd20; m_sel[1] = 8'd20; put_sels();
        wr(3'd0, 32'h0002_00FF);
        gpio_in[20] = 1'b0; settle();
        wr(3'd4, 32'hFF);
        gpio_in[20] = 1'b1; settle();
        check("R10 rise", {24'b0, irq_out} & 32'h3, 32'h1);
        wr(3'd4, 32'h01);
        gpio_in[20] = 1'b0; settle();
        check("R10 fall", {24'b0, irq_out} & 32'h3, 32'h2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule